// File: doc/BRIEF.md
# Display Bring-Up Script Player

This block runs a byte-coded power-up script for a panel with an 8-bit parallel write bus. The script is held in a ROM that is set by a parameter. A one-cycle pulse on `start_i` plays it from the first byte to the last. Ordinary bytes go onto the bus as single write strobes. A reserved prefix byte marks an escape, and the byte after it selects one of five actions: drive the chip-select line, wait a number of milliseconds, pulse the panel reset low, pick command or data mode on the register-select line, or stop the script.

A typical script holds the panel deselected and gives it two long reset pulses, with settling waits between them. It then selects the panel and writes a series of registers. Each register index goes out in command mode and each value in data mode, every 16-bit quantity as two bytes with the high byte first. The display-on write comes last and is followed by a short wait. The script then deselects the panel and ends. Millisecond timing comes from a clock-frequency parameter, so every wait is a whole number of millisecond ticks. `done_o` goes high when the script ends and stays high until the next start.

Top module: `esc_player`

## Requirements
- R1: While reset is asserted, the bus is idle: `lcd_cs_no`=1, `lcd_rst_no`=1, `lcd_rs_o`=0, `lcd_wr_no`=1, `lcd_d_o`=0x00 and `done_o`=0. The block stays idle until `start_i` is pulsed.
- R2: A script byte that is not the prefix (0xFF by default) is written to `lcd_d_o`. `lcd_wr_no` goes low for exactly one clock, and the data is held stable through the rising strobe edge. Two back-to-back plain bytes have their falling strobe edges 2 clocks apart, and bytes go out in script order.
- R3: The pair prefix, 0xFF writes one literal 0xFF byte to the bus.
- R4: The pair prefix, 0x1v sets the chip select: v=1 selects the panel (`lcd_cs_no`=0) and v=0 deselects it (`lcd_cs_no`=1).
- R5: The pair prefix, 0x3v sets `lcd_rs_o` to v (0 = command, 1 = data). The level applies to every byte written after it.
- R6: The pair prefix, 0x80+N (N from 0 to 126) waits N milliseconds. When the pair sits between two plain bytes, their falling strobe edges are 4 + N*TICKS_PER_MS clocks apart.
- R7: The pair prefix, 0x2N holds `lcd_rst_no` low for exactly (16*N+2)*TICKS_PER_MS clocks, once. N=15 gives the longest pulse. No write strobe occurs while the reset line is low.
- R8: The pair prefix, 0x00 ends the script and raises `done_o`. Bytes after it are never written, and no write strobe occurs while `done_o` is high.
- R9: A `start_i` pulse while a script is running is ignored: the run keeps its length and its writes. A pulse after `done_o` replays the whole script from its first byte.
- R10: When the script runs out of bytes without an end pair, `done_o` is raised as if an end pair had been read.
- R11: An escape argument that matches none of the codes above is a no-op. It does not write, and it does not change the chip-select, reset or register-select lines.
- R12: `done_o` stays high until `start_i` is pulsed, and it is low again one clock after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | One-cycle pulse that launches the script |
| done_o | output | 1 | High after the script has ended, until the next start |
| lcd_cs_no | output | 1 | Panel chip select, active low |
| lcd_rst_no | output | 1 | Panel reset, active low |
| lcd_rs_o | output | 1 | Register select: 0 command, 1 data |
| lcd_wr_no | output | 1 | Write strobe, active low |
| lcd_d_o | output | 8 | Parallel data byte |

## Verification
The bench builds the main instance with CLK_HZ=3000, which gives three clocks per millisecond. At that rate an 18 ms reset pulse takes 54 clocks and a 3 ms wait takes 9, so exact widths and gaps are measured in a short run. Its 41-byte script uses every escape code, including a no-op argument, a doubled prefix and a byte placed after the end pair. A second instance, built with a 4-byte script that has no end pair, brings the run-out-of-bytes case within reach.

// File: rtl/esc_player_pkg.sv
package esc_player_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_ARG,
    ST_STROBE,
    ST_WAIT,
    ST_RSTLOW,
    ST_DONE
  } state_e;

  typedef enum logic [2:0] {
    OP_END,
    OP_LIT,
    OP_DELAY,
    OP_SEL,
    OP_RST,
    OP_RS,
    OP_NOP
  } op_e;

  // upper nibble of a short escape argument (bit 7 clear)
  localparam logic [2:0] GRP_SEL = 3'd1;
  localparam logic [2:0] GRP_RST = 3'd2;
  localparam logic [2:0] GRP_RS  = 3'd3;

  function automatic op_e decode_arg(input logic [7:0] arg, input logic [7:0] prefix);
    op_e op;
    if (arg == prefix)      op = OP_LIT;
    else if (arg == 8'h00)  op = OP_END;
    else if (arg[7])        op = OP_DELAY;
    else begin
      case (arg[6:4])
        GRP_SEL: op = OP_SEL;
        GRP_RST: op = OP_RST;
        GRP_RS:  op = OP_RS;
        default: op = OP_NOP;
      endcase
    end
    return op;
  endfunction

endpackage

// File: rtl/esc_script_rom.sv
module esc_script_rom #(
  parameter int unsigned LEN = 2,
  parameter int unsigned AW  = 2,
  parameter logic [8*LEN-1:0] BYTES = '0
) (
  input  logic [AW-1:0] addr_i,
  output logic [7:0]    byte_o
);

  logic [7:0] rom [LEN];

  // byte 0 sits in the most significant slot so scripts read left to right
  for (genvar i = 0; i < LEN; i++) begin : g_slot
    assign rom[i] = BYTES[8*(LEN-1-i) +: 8];
  end

  always_comb begin
    byte_o = 8'h00;
    if (32'(addr_i) < LEN) byte_o = rom[addr_i];
  end

endmodule

// File: rtl/esc_wait_timer.sv
module esc_wait_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] count_i,
  output logic          last_o
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)              cnt_d = count_i;
    else if (cnt_q != '0)    cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // a load of C keeps the waiting state for exactly C clocks
  assign last_o = (cnt_q == CW'(1));

endmodule

// File: rtl/esc_player.sv
module esc_player
  import esc_player_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter logic [7:0]  ESC_BYTE   = 8'hFF,
  parameter int unsigned SCRIPT_LEN = 38,
  parameter logic [8*SCRIPT_LEN-1:0] SCRIPT = {
    8'hFF, 8'h10, 8'hFF, 8'hB2, 8'hFF, 8'h2F, 8'hFF, 8'hB2,
    8'hFF, 8'h2F, 8'hFF, 8'hB2, 8'hFF, 8'h11, 8'hFF, 8'hB2,
    8'hFF, 8'h30, 8'h00, 8'h07, 8'hFF, 8'h31, 8'h00, 8'h01,
    8'hFF, 8'h30, 8'h00, 8'h07, 8'hFF, 8'h31, 8'h01, 8'h33,
    8'hFF, 8'h8A, 8'hFF, 8'h10, 8'hFF, 8'h00
  }
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output logic       done_o,
  output logic       lcd_cs_no,
  output logic       lcd_rst_no,
  output logic       lcd_rs_o,
  output logic       lcd_wr_no,
  output logic [7:0] lcd_d_o
);

  localparam int unsigned TICKS_PER_MS = CLK_HZ / 1000;
  localparam int unsigned MAX_WAIT     = (15 * 16 + 2) * TICKS_PER_MS;
  localparam int unsigned CW           = $clog2(MAX_WAIT + 1);
  localparam int unsigned AW           = $clog2(SCRIPT_LEN + 1);
  localparam logic [CW-1:0] TPM_W      = CW'(TICKS_PER_MS);

  // reset synchroniser: asserts at once, releases on the clock
  logic [1:0] rsync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  state_e        state_q, state_d;
  logic [AW-1:0] pc_q, pc_d;
  logic          cs_n_q, cs_n_d;
  logic          prst_n_q, prst_n_d;
  logic          rs_q, rs_d;
  logic          wr_n_q, wr_n_d;
  logic [7:0]    dat_q, dat_d;
  logic          done_q, done_d;

  logic [7:0]    rom_byte;
  op_e           op;
  logic          pc_end;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_last;

  esc_script_rom #(
    .LEN   (SCRIPT_LEN),
    .AW    (AW),
    .BYTES (SCRIPT)
  ) u_rom (
    .addr_i (pc_q),
    .byte_o (rom_byte)
  );

  esc_wait_timer #(
    .CW (CW)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .load_i  (tmr_load),
    .count_i (tmr_val),
    .last_o  (tmr_last)
  );

  assign op     = decode_arg(rom_byte, ESC_BYTE);
  assign pc_end = (pc_q == AW'(SCRIPT_LEN));

  always_comb begin
    state_d  = state_q;
    pc_d     = pc_q;
    cs_n_d   = cs_n_q;
    prst_n_d = prst_n_q;
    rs_d     = rs_q;
    wr_n_d   = 1'b1;
    dat_d    = dat_q;
    done_d   = done_q;
    tmr_load = 1'b0;
    tmr_val  = '0;

    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          state_d = ST_FETCH;
          pc_d    = '0;
          done_d  = 1'b0;
        end
      end

      ST_FETCH: begin
        if (pc_end) begin
          state_d = ST_DONE;
          done_d  = 1'b1;
        end else begin
          pc_d = pc_q + AW'(1);
          if (rom_byte == ESC_BYTE) begin
            state_d = ST_ARG;
          end else begin
            wr_n_d  = 1'b0;
            dat_d   = rom_byte;
            state_d = ST_STROBE;
          end
        end
      end

      ST_ARG: begin
        if (pc_end) begin
          state_d = ST_DONE;
          done_d  = 1'b1;
        end else begin
          pc_d    = pc_q + AW'(1);
          state_d = ST_FETCH;
          case (op)
            OP_LIT: begin
              wr_n_d  = 1'b0;
              dat_d   = rom_byte;
              state_d = ST_STROBE;
            end
            OP_END: begin
              state_d = ST_DONE;
              done_d  = 1'b1;
            end
            OP_DELAY: begin
              if (rom_byte[6:0] != 7'd0) begin
                tmr_load = 1'b1;
                tmr_val  = CW'(rom_byte[6:0]) * TPM_W;
                state_d  = ST_WAIT;
              end
            end
            OP_SEL: cs_n_d = ~rom_byte[0];
            OP_RST: begin
              prst_n_d = 1'b0;
              tmr_load = 1'b1;
              tmr_val  = (CW'({rom_byte[3:0], 4'b0000}) + CW'(2)) * TPM_W;
              state_d  = ST_RSTLOW;
            end
            OP_RS:   rs_d = rom_byte[0];
            default: ;
          endcase
        end
      end

      ST_STROBE: state_d = ST_FETCH;

      ST_WAIT: begin
        if (tmr_last) state_d = ST_FETCH;
      end

      ST_RSTLOW: begin
        if (tmr_last) begin
          prst_n_d = 1'b1;
          state_d  = ST_FETCH;
        end
      end

      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pc_q     <= '0;
      cs_n_q   <= 1'b1;
      prst_n_q <= 1'b1;
      rs_q     <= 1'b0;
      wr_n_q   <= 1'b1;
      dat_q    <= 8'h00;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      pc_q     <= pc_d;
      cs_n_q   <= cs_n_d;
      prst_n_q <= prst_n_d;
      rs_q     <= rs_d;
      wr_n_q   <= wr_n_d;
      dat_q    <= dat_d;
      done_q   <= done_d;
    end
  end

  assign done_o     = done_q;
  assign lcd_cs_no  = cs_n_q;
  assign lcd_rst_no = prst_n_q;
  assign lcd_rs_o   = rs_q;
  assign lcd_wr_no  = wr_n_q;
  assign lcd_d_o    = dat_q;

endmodule

// File: rtl/esc_player_chk.sv
module esc_player_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       done_o,
  input logic       lcd_rst_no,
  input logic       lcd_wr_no,
  input logic [7:0] lcd_d_o
);

  assert_strobe_one_clk_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lcd_wr_no |=> lcd_wr_no);

  assert_data_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lcd_wr_no |=> $stable(lcd_d_o));

  assert_no_write_in_reset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lcd_rst_no |-> lcd_wr_no);

  assert_no_write_when_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> lcd_wr_no);

  assert_done_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

endmodule

bind esc_player esc_player_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .done_o     (done_o),
  .lcd_rst_no (lcd_rst_no),
  .lcd_wr_no  (lcd_wr_no),
  .lcd_d_o    (lcd_d_o)
);

// File: tb/esc_player_tb.sv
module esc_player_tb;

  localparam time         CLK_PERIOD = 10ns;
  localparam int unsigned CLK_HZ_TB  = 3000;
  localparam int unsigned TPM        = CLK_HZ_TB / 1000;
  localparam int unsigned LEN_A      = 41;
  localparam int unsigned LEN_B      = 4;
  localparam int          LIMIT      = 20000;

  localparam logic [8*LEN_A-1:0] SCRIPT_A = {
    8'hFF, 8'h10, 8'hFF, 8'h82, 8'hFF, 8'h21, 8'hFF, 8'h81,
    8'hFF, 8'h20, 8'hFF, 8'h11, 8'hFF, 8'h30, 8'h00, 8'h07,
    8'hFF, 8'h31, 8'h01, 8'h33, 8'hFF, 8'h50, 8'hFF, 8'hFF,
    8'hFF, 8'h30, 8'h00, 8'h22, 8'hFF, 8'h31, 8'hFF, 8'hFF,
    8'hA5, 8'hFF, 8'h83, 8'h5A, 8'hFF, 8'h10, 8'hFF, 8'h00,
    8'hC3
  };
  localparam logic [8*LEN_B-1:0] SCRIPT_B = {8'hFF, 8'h11, 8'h12, 8'h34};

  // expected writes {cs_n, rs, data}
  localparam int NEXP = 10;
  localparam logic [9:0] EXP_WR [NEXP] = '{
    {1'b0, 1'b0, 8'h00}, {1'b0, 1'b0, 8'h07},
    {1'b0, 1'b1, 8'h01}, {1'b0, 1'b1, 8'h33},
    {1'b0, 1'b1, 8'hFF}, {1'b0, 1'b0, 8'h00},
    {1'b0, 1'b0, 8'h22}, {1'b0, 1'b1, 8'hFF},
    {1'b0, 1'b1, 8'hA5}, {1'b0, 1'b1, 8'h5A}
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       done_o, cs_n, prst_n, rs, wr_n;
  logic [7:0] dat;
  logic       done_b, cs_n_b, prst_n_b, rs_b, wr_n_b;
  logic [7:0] dat_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  esc_player #(.CLK_HZ(CLK_HZ_TB), .ESC_BYTE(8'hFF), .SCRIPT_LEN(LEN_A), .SCRIPT(SCRIPT_A)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .done_o(done_o),
    .lcd_cs_no(cs_n), .lcd_rst_no(prst_n), .lcd_rs_o(rs), .lcd_wr_no(wr_n), .lcd_d_o(dat));

  esc_player #(.CLK_HZ(CLK_HZ_TB), .ESC_BYTE(8'hFF), .SCRIPT_LEN(LEN_B), .SCRIPT(SCRIPT_B)) u_dut_noend (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .done_o(done_b),
    .lcd_cs_no(cs_n_b), .lcd_rst_no(prst_n_b), .lcd_rs_o(rs_b), .lcd_wr_no(wr_n_b), .lcd_d_o(dat_b));

  // monitor state, written only by the monitor process
  int         cyc = 0;
  int         wcount = 0;
  logic [9:0] wlog [64];
  int         wtime [64];
  int         mon_err = 0;
  logic       prev_low = 1'b0;
  logic [7:0] prev_d = 8'h00;
  int         rcur = 0;
  int         rcnt = 0;
  int         rlen [8];
  int         wcount_b = 0;
  logic [7:0] last_b = 8'h00;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (prev_low) begin
      if (wr_n !== 1'b1) mon_err = mon_err + 1;
      if (dat !== prev_d) mon_err = mon_err + 1;
    end
    if (wr_n === 1'b0) begin
      if (wcount < 64) begin
        wlog[wcount]  = {cs_n, rs, dat};
        wtime[wcount] = cyc;
      end
      wcount = wcount + 1;
    end
    prev_low = (wr_n === 1'b0);
    prev_d   = dat;
    if (prst_n === 1'b0) rcur = rcur + 1;
    else if (rcur != 0) begin
      if (rcnt < 8) rlen[rcnt] = rcur;
      rcnt = rcnt + 1;
      rcur = 0;
    end
    if (wr_n_b === 1'b0) begin
      wcount_b = wcount_b + 1;
      last_b   = dat_b;
    end
  end

  int nchk = 0;
  int nfail = 0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk = nchk + 1;
    if (act !== exp) begin
      nfail = nfail + 1;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output int len);
    int t0;
    t0 = cyc;
    while (done_o !== 1'b1 && (cyc - t0) < 5000) @(negedge clk);
    len = cyc - t0;
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    $display("FAIL watchdog: actual expired expected finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk + 1);
    $finish;
  end

  initial begin
    int len1, len2, base;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 cs_n in reset", 32'(cs_n), 32'd1);
    chk("R1 rst_n in reset", 32'(prst_n), 32'd1);
    chk("R1 rs in reset", 32'(rs), 32'd0);
    chk("R1 wr_n in reset", 32'(wr_n), 32'd1);
    chk("R1 data in reset", 32'(dat), 32'd0);
    chk("R1 done in reset", 32'(done_o), 32'd0);
    rst_ni = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 idle without start", 32'(wcount), 32'd0);

    pulse_start();
    wait_done(len1);
    chk("R8 done raised", 32'(done_o), 32'd1);

    // table of expected bus writes (R2 R3 R4 R5 R11)
    for (int i = 0; i < NEXP; i++) begin
      chk($sformatf("R2/R3/R5/R11 write %0d {cs_n,rs,data}", i), 32'(wlog[i]), 32'(EXP_WR[i]));
    end
    chk("R8 byte after end not written", 32'(wcount), 32'(NEXP));
    chk("R2 back-to-back spacing", 32'(wtime[1] - wtime[0]), 32'd2);
    chk("R6 delay spacing", 32'(wtime[9] - wtime[8]), 32'(4 + 3 * TPM));
    chk("R7 reset pulse count", 32'(rcnt), 32'd2);
    chk("R7 reset N=1 width", 32'(rlen[0]), 32'(18 * TPM));
    chk("R7 reset N=0 width", 32'(rlen[1]), 32'(2 * TPM));
    chk("R4 deselected at end", 32'(cs_n), 32'd1);
    chk("R2 strobe width and data hold", 32'(mon_err), 32'd0);

    repeat (20) @(negedge clk);
    chk("R12 done held", 32'(done_o), 32'd1);
    chk("R8 quiet after done", 32'(wcount), 32'(NEXP));

    // R10 script without end pair
    chk("R10 done without end pair", 32'(done_b), 32'd1);
    chk("R10 writes before run-out", 32'(wcount_b), 32'd2);
    chk("R10 last byte", 32'(last_b), 32'h34);

    // R9 relaunch with a stray start mid-run
    base = wcount;
    pulse_start();
    chk("R12 done cleared by start", 32'(done_o), 32'd0);
    repeat (30) @(negedge clk);
    pulse_start();
    wait_done(len2);
    len2 = len2 + 31;
    chk("R9 run length unchanged", 32'(len2), 32'(len1));
    chk("R9 replayed write count", 32'(wcount - base), 32'(NEXP));
    chk("R9 replayed first write", 32'(wlog[base]), 32'(EXP_WR[0]));
    chk("R9 replayed last write", 32'(wlog[base + NEXP - 1]), 32'(EXP_WR[NEXP - 1]));
    chk("R2 strobe width and data hold, run 2", 32'(mon_err), 32'd0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule